// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block holds recently used virtual-to-physical page mappings in a fully associative array of 32 entries. Every cycle in which `lookup_en` is high, the page number in the upper bits of `lookup_va` is compared against all stored tags in parallel. The result appears in the same cycle as exactly one of three outcomes:

- a hit, with the translated physical address;
- a miss;
- a protection fault.

Lookup outputs are combinational. The state updates that a lookup causes take effect at the next rising clock edge.

A page walker outside this block loads new mappings through the fill port. The block picks the entry to overwrite and shows that choice on `fill_slot` at all times. Each entry keeps a dirty flag and a recently-used flag. The recently-used flags drive replacement: a not-recently-used entry is chosen. An aging pulse on `ref_clear` resets all recently-used flags. A flush input drops every mapping at once.

Top module: `tlb_fa`

## Requirements
- R1: While `lookup_en` is high, exactly one of `hit`, `miss` and `fault` is 1 in that cycle. While `lookup_en` is low, all three are 0.
- R2: A lookup hits when a valid entry's tag equals `lookup_va[31:12]` and the access is allowed. The entry allows a read (`lookup_write`=0) if its read permission is 1, and a write (`lookup_write`=1) if its write permission is 1. On a hit, `phys_addr` is {entry physical page, `lookup_va[11:0]`}. In every other cycle `phys_addr` is 0.
- R3: A lookup whose page number matches no valid entry gives `miss`.
- R4: A lookup that matches a valid entry but lacks the needed permission gives `fault` instead of `hit`. It changes neither the dirty flag nor the recently-used flag of any entry.
- R5: A write that hits sets the entry's dirty flag. On a hit, `look_dirty` shows the entry's dirty flag as stored before that access. On any other lookup outcome it is 0.
- R6: Every lookup that hits sets the matched entry's recently-used flag.
- R7: `fill_slot` names the lowest-indexed invalid entry if there is one. Otherwise it names the lowest-indexed valid entry whose recently-used flag is 0. A fill (`fill_en`) writes tag, physical page and permissions into that entry, marks it valid, and clears its dirty and recently-used flags.
- R8: When every entry is valid and recently used, `fill_slot` is 0. A fill in that state clears the recently-used flags of all entries.
- R9: A `ref_clear` pulse clears all recently-used flags. If a hit occurs in the same cycle, the hit entry's flag ends up set.
- R10: A `flush` pulse invalidates every entry in one cycle. After it, every lookup misses. `flush` wins over a fill in the same cycle.
- R11: After reset, all entries are invalid and `fill_slot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_en | input | 1 | Lookup request this cycle |
| lookup_write | input | 1 | 1 for a write access, 0 for a read |
| lookup_va | input | 32 | Virtual address: page number [31:12], offset [11:0] |
| hit | output | 1 | Translation found and access permitted |
| miss | output | 1 | No valid entry for the page |
| fault | output | 1 | Entry found, permission denied |
| phys_addr | output | 30 | Physical page joined with the offset on a hit |
| look_dirty | output | 1 | Stored dirty flag of the hit entry |
| fill_en | input | 1 | Load a mapping into the entry named by `fill_slot` |
| fill_vpn | input | 20 | Virtual page tag to load |
| fill_ppn | input | 18 | Physical page to load |
| fill_rd | input | 1 | Read permission to load |
| fill_wr | input | 1 | Write permission to load |
| fill_slot | output | 5 | Entry the next fill will overwrite |
| ref_clear | input | 1 | Clear all recently-used flags |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest case to reach is the fallback victim choice. It needs every one of the 32 entries valid and recently used at the same moment. The bench fills the whole array, then issues one permitted access to each entry, using a write for the one entry that lacks read permission. It then checks that `fill_slot` is 0. Next it fills a new page and checks two things: the new page hits, and the following victim is entry 1. That second result shows the fallback fill cleared every other recently-used flag.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lookup_en,
  input  logic                   lookup_write,
  input  logic [VPN_W+OFF_W-1:0] lookup_va,
  output logic                   hit,
  output logic                   miss,
  output logic                   fault,
  output logic [PPN_W+OFF_W-1:0] phys_addr,
  output logic                   look_dirty,
  input  logic                   fill_en,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  output logic [$clog2(ENTRIES)-1:0] fill_slot,
  input  logic                   ref_clear,
  input  logic                   flush
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, ref_q, dirty_q, rd_q, wr_q;
  logic [ENTRIES-1:0] match, ref_n;
  logic [IDX_W-1:0] hit_idx;
  logic             matched, allowed;

  wire [VPN_W-1:0] vpn = lookup_va[VPN_W+OFF_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = valid_q[i] && (tag_q[i] == vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign matched    = |match;
  assign allowed    = lookup_write ? wr_q[hit_idx] : rd_q[hit_idx];
  assign hit        = lookup_en && matched && allowed;
  assign fault      = lookup_en && matched && !allowed;
  assign miss       = lookup_en && !matched;
  assign phys_addr  = hit ? {ppn_q[hit_idx], lookup_va[OFF_W-1:0]} : '0;
  assign look_dirty = hit && dirty_q[hit_idx];

  wire [ENTRIES-1:0] cand = valid_q & ~ref_q;
  wire inv_any  = ~&valid_q;
  wire cand_any = |cand;

  always_comb begin
    fill_slot = '0;
    if (inv_any) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!valid_q[i]) fill_slot = IDX_W'(i);
    end else begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (cand[i]) fill_slot = IDX_W'(i);
    end
  end

  wire do_fill = fill_en && !flush;

  always_comb begin
    ref_n = ref_q;
    if (ref_clear || (do_fill && !inv_any && !cand_any)) ref_n = '0;
    if (do_fill) ref_n[fill_slot] = 1'b0;
    if (hit) ref_n[hit_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else begin
      ref_q <= ref_n;
      if (hit && lookup_write) dirty_q[hit_idx] <= 1'b1;
      if (flush) begin
        valid_q <= '0;
      end else if (fill_en) begin
        valid_q[fill_slot] <= 1'b1;
        tag_q[fill_slot]   <= fill_vpn;
        ppn_q[fill_slot]   <= fill_ppn;
        rd_q[fill_slot]    <= fill_rd;
        wr_q[fill_slot]    <= fill_wr;
        dirty_q[fill_slot] <= 1'b0;
      end
    end
  end

  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_en |-> $countones({hit, miss, fault}) == 1);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_en |-> !hit && !miss && !fault);

  assert_fault_no_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fill_en && !flush && !ref_clear) |=> $stable(ref_q) && $stable(dirty_q));

  assert_write_marks_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lookup_write && !fill_en && !flush) |=>
      (!(hit && lookup_va == $past(lookup_va)) || look_dirty));

  assert_hit_sets_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fill_en) |=> ref_q[$past(hit_idx)]);

  assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> valid_q[$past(fill_slot)]);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit && !fault);
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
  logic clk = 0, rst_n = 0;
  logic lookup_en = 0, lookup_write = 0;
  logic [31:0] lookup_va = 0;
  logic hit, miss, fault, look_dirty;
  logic [29:0] phys_addr;
  logic fill_en = 0, fill_rd = 0, fill_wr = 0, ref_clear = 0, flush = 0;
  logic [19:0] fill_vpn = 0;
  logic [17:0] fill_ppn = 0;
  logic [4:0] fill_slot;

  int checks = 0, fails = 0;
  bit done = 0;
  logic r_hit, r_miss, r_fault, r_dirty;
  logic [29:0] r_pa;

  always #2.5 clk = ~clk;

  tlb_fa u_tlb_fa (.clk, .rst_n, .lookup_en, .lookup_write, .lookup_va, .hit, .miss,
    .fault, .phys_addr, .look_dirty, .fill_en, .fill_vpn, .fill_ppn, .fill_rd,
    .fill_wr, .fill_slot, .ref_clear, .flush);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(logic [19:0] vpn, logic [11:0] off, logic wr, logic clr = 0);
    @(negedge clk);
    lookup_en = 1; lookup_write = wr; lookup_va = {vpn, off}; ref_clear = clr;
    #1;
    r_hit = hit; r_miss = miss; r_fault = fault; r_pa = phys_addr; r_dirty = look_dirty;
    @(posedge clk); #1;
    lookup_en = 0; lookup_write = 0; ref_clear = 0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [17:0] ppn, logic rd, logic wr);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_rd = rd; fill_wr = wr;
    @(posedge clk); #1;
    fill_en = 0;
  endtask

  task automatic pulse_clear();
    @(negedge clk); ref_clear = 1;
    @(posedge clk); #1; ref_clear = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 slot", fill_slot, 0);
    chk("R1 idle", {hit, miss, fault}, 0);
    access(20'h100, 0, 0);
    chk("R11 miss", {r_hit, r_miss, r_fault}, 3'b010);
  endtask

  task automatic t_fill_all();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      chk("R7 invalid first", fill_slot, i);
      fill(20'h100 + i, 18'h200 + i, i != 5, (i % 2 == 0) || i == 5);
    end
    @(negedge clk);
    chk("R7 unref valid", fill_slot, 0);
  endtask

  task automatic t_hit_miss();
    access(20'h103, 12'hABC, 0);
    chk("R2 hit", {r_hit, r_miss, r_fault}, 3'b100);
    chk("R2 phys", r_pa, {18'h203, 12'hABC});
    access(20'h777, 12'h123, 0);
    chk("R3 miss", {r_hit, r_miss, r_fault}, 3'b010);
    chk("R2 pa zero", r_pa, 0);
  endtask

  task automatic t_ref_victim();
    access(20'h100, 0, 0);
    @(negedge clk); chk("R6 ref0", fill_slot, 1);
    access(20'h101, 0, 0);
    access(20'h102, 0, 0);
    @(negedge clk); chk("R6 ref skip", fill_slot, 4);
  endtask

  task automatic t_clear();
    pulse_clear();
    @(negedge clk); chk("R9 cleared", fill_slot, 0);
    access(20'h100, 0, 0, 1);
    @(negedge clk); chk("R9 hit wins", fill_slot, 1);
  endtask

  task automatic t_fault();
    access(20'h101, 12'h010, 1);
    chk("R4 write fault", {r_hit, r_miss, r_fault}, 3'b001);
    chk("R4 pa zero", r_pa, 0);
    access(20'h105, 0, 0);
    chk("R4 read fault", {r_hit, r_miss, r_fault}, 3'b001);
    access(20'h100, 0, 0);
    @(negedge clk); chk("R4 no ref", fill_slot, 1);
  endtask

  task automatic t_dirty();
    access(20'h102, 0, 1);
    chk("R5 write hit", r_hit, 1);
    chk("R5 dirty before", r_dirty, 0);
    access(20'h102, 0, 0);
    chk("R5 dirty after", r_dirty, 1);
    access(20'h104, 0, 0);
    chk("R5 clean", r_dirty, 0);
  endtask

  task automatic t_all_ref();
    for (int i = 0; i < 32; i++) access(20'h100 + i, 0, i == 5);
    @(negedge clk); chk("R8 fallback", fill_slot, 0);
    fill(20'h300, 18'h3FF, 1, 1);
    access(20'h300, 12'h001, 0);
    chk("R8 new hit", r_pa, {18'h3FF, 12'h001});
    access(20'h100, 0, 0);
    chk("R8 old gone", r_miss, 1);
    @(negedge clk); chk("R8 refs cleared", fill_slot, 1);
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1; fill_en = 1; fill_vpn = 20'h555; fill_ppn = 1;
    fill_rd = 1; fill_wr = 1;
    @(posedge clk); #1; flush = 0; fill_en = 0;
    access(20'h300, 0, 0);
    chk("R10 flushed", {r_hit, r_miss, r_fault}, 3'b010);
    access(20'h555, 0, 0);
    chk("R10 beats fill", r_miss, 1);
    @(negedge clk); chk("R10 slot", fill_slot, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_fill_all();
    t_hit_miss();
    t_ref_victim();
    t_clear();
    t_fault();
    t_dirty();
    t_all_ref();
    t_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule